// File: doc/BRIEF.md
# Reset and Power-State Sequencer for a Clock Distribution Device

This block decides which reset condition of a clock-distribution device is in force and steps the device through recovery. It handles five sources: a power-on detector, an asynchronous active-low reset pin, a soft-reset request written into the control register, a self-clearing reload request, and an active-low sleep pin. For each recovery a strap input picks where settings come from. With the strap at 1, settings are loaded from nonvolatile storage through a request/done handshake. With the strap at 0, a one-cycle pulse loads the built-in defaults.

While a recovery runs, the block holds the output drivers static. Power-on and pin recoveries also issue a single sync pulse that phase-aligns the outputs. A down-counter then times the wait before the outputs may toggle again. Each wait length is a parameter in reference-clock cycles and depends on the source and the strap.

Register writes arrive as a valid/ready stream of address and data beats. A beat is accepted on a cycle where both `wr_valid` and `wr_ready` are high. While the block is in reset, `wr_ready` stays low and the writer must hold its beat. Sleep only gates the driver enable, and it changes that enable only on cycles that the clock network marks as safe.

Top module: `rst_seq_ctrl`

## Requirements
- R1: While `por_n` is low, `in_reset`, `out_hold` and `out_en` are high, `wr_ready` is low and the control register reads `CTRL0_RST` (0x18). After release, the restore follows the strap and the outputs stay held for `T_POR` cycles of waiting.
- R2: While the synchronised reset pin is low, the block stays in reset and the control register reads `CTRL0_RST`. After release, the restore follows the strap and the wait lasts `T_PIN_DEF` cycles (strap 0) or `T_PIN_NV` cycles (strap 1).
- R3: An accepted write to address 0x000 whose data has bits 2 and 5 both set enters soft reset. The whole written byte is stored. Reset stays asserted until a `sclk_edge` strobe arrives; on that cycle bits 2 and 5 clear and every other bit keeps its value.
- R4: After a soft reset is released, the restore follows the strap, the wait lasts `T_SOFT` cycles, and no sync pulse is issued.
- R5: An accepted write to address 0xB02 with data bit 1 set and the strap at 1 starts a nonvolatile reload followed by a wait of `T_RELOAD` cycles. With the strap at 0 the same write has no effect.
- R6: `nvm_load_req` stays high until a cycle with `nvm_load_done` high. Waiting starts only after that cycle. With the strap at 0, `dflt_load` pulses for exactly one cycle instead and no load request is made.
- R7: Sources rank as power-on > pin > soft > reload. An event of lower rank than the recovery in progress is ignored; such a soft-reset write stores its byte with bits 2 and 5 cleared. An event of equal or higher rank restarts recovery, and the load request drops at once.
- R8: `wr_ready` is low exactly while `in_reset` is high. Writes are accepted at all other times, sleep included.
- R9: While `pd_n` is low, `out_en` falls only on a cycle with `safe_pt` high, and it rises again only on such a cycle after `pd_n` returns high. Registers written during sleep keep their values after wake-up.
- R10: `sync_pulse` is high for exactly one cycle, the first cycle of the wait, and only for power-on and pin recoveries.
- R11: `out_hold` is high from the accepting edge of any event until the wait expires, and it is always high while `in_reset` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| por_n | input | 1 | Power-on detect, active low, asynchronous |
| rst_pin_n | input | 1 | Reset pin, active low, asynchronous |
| pd_n | input | 1 | Sleep pin, active low |
| strap_nv | input | 1 | Restore source: 1 nonvolatile, 0 built-in defaults |
| sclk_edge | input | 1 | One-cycle strobe per serial clock edge |
| safe_pt | input | 1 | Cycle on which driver enables may change |
| wr_valid | input | 1 | Register write beat valid |
| wr_ready | output | 1 | Register write beat accepted |
| wr_addr | input | AW | Register address |
| wr_data | input | DW | Register data |
| nvm_load_req | output | 1 | Nonvolatile load request |
| nvm_load_done | input | 1 | Nonvolatile load finished |
| dflt_load | output | 1 | One-cycle load of built-in defaults |
| sync_pulse | output | 1 | Output phase-alignment pulse |
| in_reset | output | 1 | Device held in reset |
| out_hold | output | 1 | Output drivers held static |
| out_en | output | 1 | Output driver enable (low in sleep) |
| ctrl0_q | output | DW | Contents of control register 0x000 |

## Verification
Every latency is counted in edges from the stimulus:
- A soft-reset or reload write takes effect on the edge that accepts it.
- The pin needs two synchroniser edges plus one hold edge before restore begins.
- Restore takes one edge for defaults, or the handshake length for a nonvolatile load.
- The wait then lasts exactly its parameter.

From these counts the bench derives the expected number of edges during which `out_hold` stays high, for each source and strap. It counts edges at falling clock edges until the hold drops, so each measurement lands on the cycle it predicts. Sync pulses, default-load pulses and load-request cycles are counted over the same window. Sleep gating is checked with `safe_pt` held low for several cycles past the synchroniser delay before the single safe strobe is given.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

  // Ranks are ordered: a larger value wins.
  typedef enum logic [2:0] {
    SRC_NONE   = 3'd0,
    SRC_RELOAD = 3'd1,
    SRC_SOFT   = 3'd2,
    SRC_PIN    = 3'd3,
    SRC_POR    = 3'd4
  } src_e;

  typedef enum logic [2:0] {
    ST_RUN   = 3'd0,
    ST_START = 3'd1,
    ST_LOAD  = 3'd2,
    ST_HOLD  = 3'd3,
    ST_WAIT  = 3'd4
  } state_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rsq_sync.sv
module rsq_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sr <= {STAGES{RST_VAL}};
    else         sr <= {sr[STAGES-2:0], d};
  end

  assign q = sr[STAGES-1];
endmodule

// File: rtl/rsq_timer.sv
module rsq_timer
  import rsq_pkg::*;
#(
  parameter int T_POR     = 7_000_000,
  parameter int T_PIN_DEF = 200,
  parameter int T_PIN_NV  = 2_000_000,
  parameter int T_SOFT    = 16,
  parameter int T_RELOAD  = 2_000_000
) (
  input  logic clk,
  input  logic arst_n,
  input  logic start,
  input  logic abort,
  input  src_e src,
  input  logic strap,
  output logic expire
);
  localparam int TMAX = imax(imax(T_POR, T_PIN_NV), imax(imax(T_PIN_DEF, T_SOFT), T_RELOAD));
  localparam int CW   = $clog2(TMAX + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] len_m1;
  logic          running;

  always_comb begin
    unique case (src)
      SRC_POR:    len_m1 = CW'(T_POR - 1);
      SRC_PIN:    len_m1 = strap ? CW'(T_PIN_NV - 1) : CW'(T_PIN_DEF - 1);
      SRC_SOFT:   len_m1 = CW'(T_SOFT - 1);
      SRC_RELOAD: len_m1 = CW'(T_RELOAD - 1);
      default:    len_m1 = '0;
    endcase
  end

  assign expire = running && (cnt == '0);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt     <= '0;
      running <= 1'b0;
    end else if (start) begin
      cnt     <= len_m1;
      running <= 1'b1;
    end else if (abort || expire) begin
      running <= 1'b0;
    end else if (running) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/rsq_outgate.sv
module rsq_outgate (
  input  logic clk,
  input  logic arst_n,
  input  logic sleep_req,
  input  logic safe_pt,
  output logic out_en
);
  // Enable only moves on a clock-safe cycle, so no shortened pulse escapes.
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)      out_en <= 1'b1;
    else if (safe_pt) out_en <= !sleep_req;
  end
endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
  import rsq_pkg::*;
#(
  parameter int            AW          = 12,
  parameter int            DW          = 8,
  parameter int            SYNC_STAGES = 2,
  parameter int            T_POR       = 7_000_000,
  parameter int            T_PIN_DEF   = 200,
  parameter int            T_PIN_NV    = 2_000_000,
  parameter int            T_SOFT      = 16,
  parameter int            T_RELOAD    = 2_000_000,
  parameter logic [DW-1:0] CTRL0_RST   = 'h18,
  parameter logic [AW-1:0] CTRL_ADDR   = 'h000,
  parameter logic [AW-1:0] RELOAD_ADDR = 'hB02,
  parameter int            SOFT_BIT_A  = 2,
  parameter int            SOFT_BIT_B  = 5,
  parameter int            RELOAD_BIT  = 1
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          rst_pin_n,
  input  logic          pd_n,
  input  logic          strap_nv,
  input  logic          sclk_edge,
  input  logic          safe_pt,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          nvm_load_req,
  input  logic          nvm_load_done,
  output logic          dflt_load,
  output logic          sync_pulse,
  output logic          in_reset,
  output logic          out_hold,
  output logic          out_en,
  output logic [DW-1:0] ctrl0_q
);
  localparam logic [DW-1:0] SOFT_MASK = (DW'(1) << SOFT_BIT_A) | (DW'(1) << SOFT_BIT_B);

  state_e        state;
  src_e          src;
  logic          strap_q;
  logic          sync_q;
  logic [DW-1:0] ctrl0;

  logic pin_q, pd_q;
  logic pin_low_s, sleep_s;
  logic wr_fire, ev_pin, ev_soft, ev_reload, any_ev, plain_wr;
  logic tmr_start, tmr_expire, tmr_strap;

  rsq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pin_sync (
    .clk(clk), .arst_n(rst_pin_n), .d(1'b1), .q(pin_q)
  );

  rsq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pd_sync (
    .clk(clk), .arst_n(por_n), .d(pd_n), .q(pd_q)
  );

  assign pin_low_s = !pin_q;
  assign sleep_s   = !pd_q;

  // Event decode with rank arbitration against the recovery in progress
  assign in_reset  = (state == ST_HOLD) || (state == ST_START);
  assign wr_ready  = !in_reset;
  assign wr_fire   = wr_valid && wr_ready;

  assign ev_pin    = pin_low_s && (src <= SRC_PIN);
  assign ev_soft   = wr_fire && (wr_addr == CTRL_ADDR) &&
                     wr_data[SOFT_BIT_A] && wr_data[SOFT_BIT_B] && (src <= SRC_SOFT);
  assign ev_reload = wr_fire && (wr_addr == RELOAD_ADDR) && wr_data[RELOAD_BIT] &&
                     strap_nv && (src <= SRC_RELOAD);
  assign any_ev    = ev_pin || ev_soft || ev_reload;
  assign plain_wr  = wr_fire && (wr_addr == CTRL_ADDR);

  assign tmr_start = !any_ev &&
                     (((state == ST_START) && !strap_nv) ||
                      ((state == ST_LOAD) && nvm_load_done));
  assign tmr_strap = (state == ST_START) ? strap_nv : strap_q;

  rsq_timer #(
    .T_POR(T_POR), .T_PIN_DEF(T_PIN_DEF), .T_PIN_NV(T_PIN_NV),
    .T_SOFT(T_SOFT), .T_RELOAD(T_RELOAD)
  ) u_timer (
    .clk(clk), .arst_n(por_n), .start(tmr_start), .abort(any_ev),
    .src(src), .strap(tmr_strap), .expire(tmr_expire)
  );

  rsq_outgate u_gate (
    .clk(clk), .arst_n(por_n), .sleep_req(sleep_s), .safe_pt(safe_pt), .out_en(out_en)
  );

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      state   <= ST_START;
      src     <= SRC_POR;
      strap_q <= 1'b0;
      sync_q  <= 1'b0;
      ctrl0   <= CTRL0_RST;
    end else begin
      sync_q <= tmr_start && ((src == SRC_POR) || (src == SRC_PIN));
      if (ev_pin) begin
        state <= ST_HOLD;
        src   <= SRC_PIN;
        ctrl0 <= CTRL0_RST;
      end else if (ev_soft) begin
        state <= ST_HOLD;
        src   <= SRC_SOFT;
        ctrl0 <= wr_data;
      end else if (ev_reload) begin
        state <= ST_START;
        src   <= SRC_RELOAD;
      end else begin
        if (plain_wr) ctrl0 <= wr_data & ~SOFT_MASK;
        unique case (state)
          ST_START: begin
            strap_q <= strap_nv;
            state   <= strap_nv ? ST_LOAD : ST_WAIT;
          end
          ST_LOAD: if (nvm_load_done) state <= ST_WAIT;
          ST_HOLD: begin
            if (src == SRC_PIN) begin
              if (!pin_low_s) state <= ST_START;
            end else if (sclk_edge) begin
              // soft bits clear on the extra serial edge; rest of byte kept
              ctrl0 <= ctrl0 & ~SOFT_MASK;
              state <= ST_START;
            end
          end
          ST_WAIT: if (tmr_expire) begin
            state <= ST_RUN;
            src   <= SRC_NONE;
          end
          default: ;
        endcase
      end
    end
  end

  assign nvm_load_req = (state == ST_LOAD);
  assign dflt_load    = (state == ST_START) && !strap_nv;
  assign sync_pulse   = sync_q;
  assign out_hold     = (state != ST_RUN);
  assign ctrl0_q      = ctrl0;
endmodule

// File: rtl/rst_seq_ctrl_chk.sv
module rst_seq_ctrl_chk (
  input logic clk,
  input logic por_n,
  input logic in_reset,
  input logic out_hold,
  input logic wr_ready,
  input logic wr_valid,
  input logic sync_pulse,
  input logic nvm_load_req,
  input logic nvm_load_done,
  input logic safe_pt,
  input logic out_en,
  input logic pin_low_s
);
  // R11: reset implies static outputs
  a_r11_reset_holds: assert property (@(posedge clk) disable iff (!por_n)
    in_reset |-> out_hold);

  // R8: no write accepted while in reset
  a_r8_no_ready_in_reset: assert property (@(posedge clk) disable iff (!por_n)
    in_reset |-> !wr_ready);

  // R10: sync is a single-cycle pulse inside the held window
  a_r10_sync_single: assert property (@(posedge clk) disable iff (!por_n)
    sync_pulse |=> !sync_pulse);
  a_r10_sync_in_hold: assert property (@(posedge clk) disable iff (!por_n)
    sync_pulse |-> out_hold);

  // R6: request held until done unless a new event intervenes
  a_r6_req_until_done: assert property (@(posedge clk) disable iff (!por_n)
    nvm_load_req && !nvm_load_done && !pin_low_s && !wr_valid |=> nvm_load_req);

  // R9: enable changes only after a safe cycle
  a_r9_en_at_safe: assert property (@(posedge clk) disable iff (!por_n)
    (out_en != $past(out_en)) |-> $past(safe_pt));
endmodule

bind rst_seq_ctrl rst_seq_ctrl_chk u_chk (
  .clk(clk), .por_n(por_n), .in_reset(in_reset), .out_hold(out_hold),
  .wr_ready(wr_ready), .wr_valid(wr_valid), .sync_pulse(sync_pulse),
  .nvm_load_req(nvm_load_req), .nvm_load_done(nvm_load_done),
  .safe_pt(safe_pt), .out_en(out_en), .pin_low_s(pin_low_s)
);

// File: tb/rst_seq_ctrl_test.sv
`timescale 1ns/1ps
module rst_seq_ctrl_test;
  localparam int T_POR = 20, T_PIN_DEF = 5, T_PIN_NV = 12, T_SOFT = 4, T_RELOAD = 9;
  localparam int LD_DLY = 3;
  localparam logic [7:0] C0_RST = 8'h18;
  localparam int K_POR = 0, K_PIN = 1, K_SOFT = 2, K_RLD = 3;

  typedef struct packed {
    logic [1:0] kind;
    logic       strap;
    logic [7:0] wdata;
    logic [7:0] exp_ctrl;
  } row_t;

  localparam row_t ROWS [7] = '{
    '{2'd0, 1'b0, 8'h00, 8'h18},
    '{2'd0, 1'b1, 8'h00, 8'h18},
    '{2'd1, 1'b0, 8'h00, 8'h18},
    '{2'd1, 1'b1, 8'h00, 8'h18},
    '{2'd2, 1'b0, 8'hA5, 8'h81},
    '{2'd2, 1'b1, 8'h64, 8'h40},
    '{2'd3, 1'b1, 8'h02, 8'h40}
  };

  logic clk = 0;
  logic por_n = 0, rst_pin_n = 0, pd_n = 1, strap_nv = 0;
  logic sclk_edge = 0, safe_pt = 0, wr_valid = 0;
  logic [11:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic nvm_load_done = 0;
  logic wr_ready, nvm_load_req, dflt_load, sync_pulse, in_reset, out_hold, out_en;
  logic [7:0] ctrl0_q;

  int nchk = 0, nfail = 0;
  bit resp_en = 1;
  bit finished = 0;
  int rcnt = 0;

  always #5 clk = ~clk;

  rst_seq_ctrl #(
    .T_POR(T_POR), .T_PIN_DEF(T_PIN_DEF), .T_PIN_NV(T_PIN_NV),
    .T_SOFT(T_SOFT), .T_RELOAD(T_RELOAD)
  ) uut (
    .clk(clk), .por_n(por_n), .rst_pin_n(rst_pin_n), .pd_n(pd_n), .strap_nv(strap_nv),
    .sclk_edge(sclk_edge), .safe_pt(safe_pt), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .nvm_load_req(nvm_load_req),
    .nvm_load_done(nvm_load_done), .dflt_load(dflt_load), .sync_pulse(sync_pulse),
    .in_reset(in_reset), .out_hold(out_hold), .out_en(out_en), .ctrl0_q(ctrl0_q)
  );

  // Storage model: answers a request after LD_DLY sampled cycles
  always @(negedge clk) begin
    if (nvm_load_req && resp_en) begin
      rcnt = rcnt + 1;
      nvm_load_done = (rcnt == LD_DLY);
    end else begin
      rcnt = 0;
      nvm_load_done = 0;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int wait_len(input int k, input bit s);
    case (k)
      K_POR:   return T_POR;
      K_PIN:   return s ? T_PIN_NV : T_PIN_DEF;
      K_SOFT:  return T_SOFT;
      default: return T_RELOAD;
    endcase
  endfunction

  // edges from stimulus to restore start: POR 1, pin 2 sync + hold + start, soft/reload 2
  function automatic int exp_hold(input int k, input bit s);
    int base;
    base = (k == K_POR) ? 1 : (k == K_PIN) ? 4 : 2;
    return base + (s ? LD_DLY : 0) + wait_len(k, s);
  endfunction

  function automatic string tag(input int k);
    case (k)
      K_POR:   return "R1";
      K_PIN:   return "R2";
      K_SOFT:  return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    wr_addr = a; wr_data = d; wr_valid = 1;
  endtask

  task automatic run_row(input row_t r);
    int n, sy, df, nv, k;
    k = int'(r.kind);
    strap_nv = r.strap;
    @(negedge clk);
    case (k)
      K_POR: begin
        por_n = 0;
        @(negedge clk);
        chk("R1", "in_reset during por", int'(in_reset), 1);
        chk("R1", "ctrl0 during por", int'(ctrl0_q), int'(C0_RST));
        chk("R8", "wr_ready during por", int'(wr_ready), 0);
        por_n = 1;
      end
      K_PIN: begin
        rst_pin_n = 0;
        repeat (3) @(negedge clk);
        chk("R2", "in_reset pin low", int'(in_reset), 1);
        chk("R8", "wr_ready pin low", int'(wr_ready), 0);
        rst_pin_n = 1;
      end
      K_SOFT: begin
        wr(12'h000, r.wdata);
        @(negedge clk);
        wr_valid = 0;
        chk("R3", "in_reset soft", int'(in_reset), 1);
        chk("R3", "ctrl0 raw byte", int'(ctrl0_q), int'(r.wdata));
        repeat (2) @(negedge clk);
        chk("R3", "reset held until sclk", int'(in_reset), 1);
        sclk_edge = 1;
      end
      default: wr(12'hB02, r.wdata);
    endcase
    n = 0;
    sy = int'(sync_pulse); df = int'(dflt_load); nv = int'(nvm_load_req);
    while (n < 500) begin
      @(negedge clk);
      wr_valid = 0; sclk_edge = 0;
      n++;
      sy += int'(sync_pulse); df += int'(dflt_load); nv += int'(nvm_load_req);
      if (!out_hold) break;
    end
    chk(tag(k), "hold edges", n, exp_hold(k, r.strap));
    chk("R10", "sync count", sy, (k <= K_PIN) ? 1 : 0);
    chk("R6", "default pulses", df, r.strap ? 0 : 1);
    chk("R6", "load request cycles", nv, r.strap ? LD_DLY : 0);
    chk((k == K_SOFT) ? "R3" : tag(k), "ctrl0 after", int'(ctrl0_q), int'(r.exp_ctrl));
  endtask

  task automatic wait_idle();
    int n;
    n = 0;
    while (out_hold && n < 500) begin @(negedge clk); n++; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual expired expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_pin_n = 1;
    chk("R1", "out_hold at reset", int'(out_hold), 1);
    chk("R1", "out_en at reset", int'(out_en), 1);
    chk("R10", "sync at reset", int'(sync_pulse), 0);

    foreach (ROWS[i]) run_row(ROWS[i]);

    // R5: reload ignored with strap at 0
    strap_nv = 0;
    @(negedge clk);
    wr(12'hB02, 8'h02);
    n = 0;
    repeat (6) begin @(negedge clk); wr_valid = 0; n += int'(out_hold) + int'(nvm_load_req); end
    chk("R5", "reload with strap 0 effect", n, 0);

    // R7: lower-rank soft write during power-on wait is ignored
    strap_nv = 0;
    por_n = 0; @(negedge clk); por_n = 1;
    n = 0;
    repeat (5) begin @(negedge clk); n++; end
    wr(12'h000, 8'hA5);
    @(negedge clk); n++; wr_valid = 0;
    chk("R7", "soft ignored in por", int'(in_reset), 0);
    chk("R7", "masked byte stored", int'(ctrl0_q), 8'h81);
    while (out_hold && n < 500) begin @(negedge clk); n++; end
    chk("R7", "por wait unchanged", n, exp_hold(K_POR, 1'b0));

    // R7: pin reset aborts a reload in its load phase
    strap_nv = 1;
    @(negedge clk);
    wr(12'hB02, 8'h02);
    @(negedge clk); wr_valid = 0;
    @(negedge clk);
    chk("R6", "load requested", int'(nvm_load_req), 1);
    rst_pin_n = 0;
    @(negedge clk);
    chk("R7", "request dropped on pin", int'(nvm_load_req), 0);
    chk("R7", "pin reset taken", int'(in_reset), 1);
    rst_pin_n = 1;
    wait_idle();
    chk("R2", "recovered after pin", int'(out_hold), 0);

    // R6: nothing proceeds without done
    resp_en = 0;
    @(negedge clk);
    wr(12'hB02, 8'h02);
    @(negedge clk); wr_valid = 0;
    repeat (20) @(negedge clk);
    chk("R6", "request held without done", int'(nvm_load_req), 1);
    chk("R6", "still held without done", int'(out_hold), 1);
    resp_en = 1;
    wait_idle();
    chk("R6", "completes after done", int'(out_hold), 0);

    // R9: sleep gating at safe points, registers retained
    pd_n = 0;
    repeat (5) @(negedge clk);
    chk("R9", "enable kept until safe", int'(out_en), 1);
    chk("R8", "ready during sleep", int'(wr_ready), 1);
    wr(12'h000, 8'h42);
    @(negedge clk); wr_valid = 0;
    chk("R9", "write in sleep", int'(ctrl0_q), 8'h42);
    safe_pt = 1; @(negedge clk); safe_pt = 0;
    chk("R9", "enable off at safe", int'(out_en), 0);
    pd_n = 1;
    repeat (5) @(negedge clk);
    chk("R9", "enable stays off until safe", int'(out_en), 0);
    safe_pt = 1; @(negedge clk); safe_pt = 0;
    chk("R9", "enable on at safe", int'(out_en), 1);
    chk("R9", "register kept on wake", int'(ctrl0_q), 8'h42);
    chk("R11", "no hold from sleep", int'(out_hold), 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule